// File: doc/BRIEF.md
# Split Load/Store Data Address Translator

This block is a first-level data TLB made of two independent arrays that answer different kinds of access. Loads look up only a set-associative array that holds 4 KB translations. Stores look up only a small fully associative array whose entries may each cover a page of any supported size. Each cycle in which the block is ready it accepts one request: a virtual page number and a flag that marks the access as a store. One cycle later it returns a registered result. On a hit the result carries the physical page number and the page size. On a miss it raises a miss flag instead.

After a miss the block stalls new requests until an external page walker returns a fill. A fill carries the virtual page, physical page, page size and whether a load or a store caused it. The two arrays follow deliberately different fill rules. Every fill, whatever its origin, installs a 4 KB translation in the load-side array. Only fills that come from stores are written into the store-side array. A global flush input empties both arrays in one cycle.

The control is a two-state machine. In `ST_READY` requests are accepted. An accepted request that misses takes the transition `take_miss` to `ST_MISS_WAIT`. There the request-ready output stays low until a fill arrives, which takes the transition `fill_return` back to `ST_READY`. Hits and fills that arrive while the block is in `ST_READY` leave the state unchanged.

Top module: `split_dtlb`

## Requirements
- R1: A store lookup consults only the store-side array. A store whose page is present only in the load-side array misses.
- R2: A load lookup consults only the load-side array. A load to an address covered only by a large store-side entry misses.
- R3: Every fill writes the load-side array with a 4 KB translation of the filled virtual page. Its physical page is the fill's physical page with the bits below the fill's page size taken from the virtual page. This holds for fills from both loads and stores.
- R4: A fill from a load does not write the store-side array.
- R5: Each store-side entry matches only on the virtual page bits above its own page offset. Size codes are 0 = 4 KB, 1 = 2 MB, 2 = 4 MB and 3 = 1 GB, covering 0, 9, 10 and 18 low page-number bits. A store hit returns the entry's physical page with those offset bits passed through from the request, and returns the entry's size code.
- R6: The load-side array has 16 sets of 4 ways. It is indexed by the low 4 virtual page bits, and a load hit always reports size code 0.
- R7: A load-side fill takes an invalid way first. Otherwise it takes the way chosen by a per-set tree pseudo-LRU that is updated on load hits and fills.
- R8: A store-side fill takes the lowest invalid entry first. Otherwise it takes the entry under a round-robin pointer that advances by one on each such replacement.
- R9: A result (`rsp_valid`) appears exactly one cycle after a request is accepted and lasts one cycle. Hit and miss are never raised together.
- R10: After an accepted miss, `req_ready` stays low until the cycle after `fill_valid` is seen.
- R11: A fill whose page matches an existing valid entry replaces that entry's translation in place.
- R12: A `flush` cycle invalidates every entry of both arrays, so the next lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries of both arrays |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vpn | input | VPN_W | Virtual page number of the request |
| req_is_store | input | 1 | 1 = store access, 0 = load access |
| rsp_valid | output | 1 | Result of the request accepted last cycle |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation not found; a fill is awaited |
| rsp_ppn | output | PPN_W | Physical page number on a hit |
| rsp_size | output | 2 | Page size code on a hit |
| fill_valid | input | 1 | Fill from the page walker |
| fill_vpn | input | VPN_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill (page base) |
| fill_size | input | 2 | Page size code of the fill |
| fill_is_store | input | 1 | Fill was caused by a store miss |

## Verification
The bench targets the asymmetry between the two arrays. A store after a load-only fill must miss; a design that shared the arrays would hit there. A load inside a 2 MB store entry but away from the filled sub-page must miss; a design that installed the whole large page into the load side, or let loads see the store side, would return a translation. Mixed-size store entries are checked for offset pass-through at 2 MB, 4 MB and 1 GB, where a wrong mask width gives a wrong physical page. A four-way set is driven to eviction after one hit has reordered its pseudo-LRU tree, so FIFO or plain LRU choices evict the wrong page. Seventeen store fills after a flush confirm that the round-robin pointer replaces entry 0. Overwrites of an existing page must replace it in both arrays, not keep a stale duplicate.

// File: rtl/split_dtlb_pkg.sv
package split_dtlb_pkg;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2,
        PG_1G = 2'd3
    } pg_size_e;

    // Number of low virtual-page-number bits that fall inside the page offset
    function automatic int unsigned page_off_bits(input pg_size_e s);
        unique case (s)
            PG_4K:   return 0;
            PG_2M:   return 9;
            PG_4M:   return 10;
            default: return 18;
        endcase
    endfunction

    // Mask of the page-number bits that pass through untranslated
    function automatic logic [63:0] page_mask(input pg_size_e s);
        return (64'd1 << page_off_bits(s)) - 64'd1;
    endfunction

endpackage

// File: rtl/store_fa_array.sv
module store_fa_array
    import split_dtlb_pkg::*;
#(
    parameter int VPN_W   = 36,
    parameter int PPN_W   = 28,
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [1:0]       lk_size,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_size
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    pg_size_e           size_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [VPN_W-1:0] off_msk;
        assign off_msk     = VPN_W'(page_mask(size_q[g]));
        assign lk_match[g] = vld_q[g] && ((lk_vpn & ~off_msk) == (tag_q[g] & ~off_msk));
        assign fl_match[g] = vld_q[g] && ((fill_vpn & ~off_msk) == (tag_q[g] & ~off_msk));
    end

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] fl_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    logic             use_rr;

    always_comb begin
        lk_idx   = '0;
        fl_idx   = '0;
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) lk_idx = IDX_W'(i);
            if (fl_match[i]) fl_idx = IDX_W'(i);
            if (!vld_q[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        use_rr = !(|fl_match) && !any_free;
    end

    logic [PPN_W-1:0] lk_pmsk;
    assign lk_pmsk = PPN_W'(page_mask(size_q[lk_idx]));
    assign lk_hit  = |lk_match;
    assign lk_ppn  = lk_hit ? ((ppn_q[lk_idx] & ~lk_pmsk) | (PPN_W'(lk_vpn) & lk_pmsk)) : '0;
    assign lk_size = lk_hit ? size_q[lk_idx] : PG_4K;

    logic [IDX_W-1:0] wr_idx;
    assign wr_idx = (|fl_match) ? fl_idx : (any_free ? free_idx : rr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[wr_idx]  <= 1'b1;
            tag_q[wr_idx]  <= fill_vpn;
            ppn_q[wr_idx]  <= fill_ppn;
            size_q[wr_idx] <= pg_size_e'(fill_size);
            if (use_rr) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/load_sa_array.sv
module load_sa_array
    import split_dtlb_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int PPN_W = 28,
    parameter int SETS  = 16,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_touch,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_size
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TREE  = (WAYS > 1) ? WAYS - 1 : 1;

    logic [WAYS-1:0]  vld_q  [SETS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
    logic [TREE-1:0]  plru_q [SETS];

    function automatic logic [WAY_W-1:0] tree_victim(input logic [TREE-1:0] t);
        int node;
        node = 0;
        for (int l = 0; l < WAY_W; l++) node = 2 * node + 1 + int'(t[node]);
        return WAY_W'(node - TREE);
    endfunction

    function automatic logic [TREE-1:0] tree_touch(input logic [TREE-1:0] t,
                                                   input logic [WAY_W-1:0] w);
        int   node;
        logic b;
        node = 0;
        for (int l = 0; l < WAY_W; l++) begin
            b       = w[WAY_W-1-l];
            t[node] = ~b;
            node    = 2 * node + 1 + int'(b);
        end
        return t;
    endfunction

    logic [IDX_W-1:0] l_set, f_set;
    logic [TAG_W-1:0] l_tag, f_tag;
    assign l_set = lk_vpn[IDX_W-1:0];
    assign l_tag = lk_vpn[VPN_W-1:IDX_W];
    assign f_set = fill_vpn[IDX_W-1:0];
    assign f_tag = fill_vpn[VPN_W-1:IDX_W];

    logic [WAYS-1:0] l_match, f_match;
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign l_match[g] = vld_q[l_set][g] && (tag_q[l_set][g] == l_tag);
        assign f_match[g] = vld_q[f_set][g] && (tag_q[f_set][g] == f_tag);
    end

    logic [WAY_W-1:0] l_way, f_hit_way, f_free_way, f_way;
    logic             f_any_free;

    always_comb begin
        l_way      = '0;
        f_hit_way  = '0;
        f_free_way = '0;
        f_any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (l_match[w]) l_way = WAY_W'(w);
            if (f_match[w]) f_hit_way = WAY_W'(w);
            if (!vld_q[f_set][w]) begin
                f_free_way = WAY_W'(w);
                f_any_free = 1'b1;
            end
        end
        if (|f_match)       f_way = f_hit_way;
        else if (f_any_free) f_way = f_free_way;
        else                 f_way = tree_victim(plru_q[f_set]);
    end

    assign lk_hit = |l_match;
    assign lk_ppn = lk_hit ? ppn_q[l_set][l_way] : '0;

    // A larger page is installed as the 4 KB slice that holds the filled address
    logic [PPN_W-1:0] f_pmsk, f_ppn4k;
    assign f_pmsk  = PPN_W'(page_mask(pg_size_e'(fill_size)));
    assign f_ppn4k = (fill_ppn & ~f_pmsk) | (PPN_W'(fill_vpn) & f_pmsk);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                plru_q[s] <= '0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                plru_q[s] <= '0;
            end
        end else begin
            if (fill_en) begin
                vld_q[f_set][f_way] <= 1'b1;
                tag_q[f_set][f_way] <= f_tag;
                ppn_q[f_set][f_way] <= f_ppn4k;
                plru_q[f_set]       <= tree_touch(plru_q[f_set], f_way);
            end
            if (lk_touch && lk_hit && !(fill_en && (f_set == l_set)))
                plru_q[l_set] <= tree_touch(plru_q[l_set], l_way);
        end
    end

endmodule

// File: rtl/split_dtlb.sv
module split_dtlb
    import split_dtlb_pkg::*;
#(
    parameter int VPN_W      = 36,
    parameter int PPN_W      = 28,
    parameter int LD_SETS    = 16,
    parameter int LD_WAYS    = 4,
    parameter int ST_ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_is_store,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [1:0]       rsp_size,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_size,
    input  logic             fill_is_store
);

    typedef enum logic {
        ST_READY     = 1'b0,
        ST_MISS_WAIT = 1'b1
    } state_e;

    state_e state_q, state_d;

    logic accept;
    assign req_ready = (state_q == ST_READY);
    assign accept    = req_valid && req_ready;

    logic             ld_hit, st_hit, sel_hit;
    logic [PPN_W-1:0] ld_ppn, st_ppn;
    logic [1:0]       st_size;

    load_sa_array #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(LD_SETS), .WAYS(LD_WAYS)
    ) u_load_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_vpn   (req_vpn),
        .lk_touch (accept && !req_is_store),
        .lk_hit   (ld_hit),
        .lk_ppn   (ld_ppn),
        .fill_en  (fill_valid),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .fill_size(fill_size)
    );

    store_fa_array #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(ST_ENTRIES)
    ) u_store_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_vpn   (req_vpn),
        .lk_hit   (st_hit),
        .lk_ppn   (st_ppn),
        .lk_size  (st_size),
        .fill_en  (fill_valid && fill_is_store),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .fill_size(fill_size)
    );

    assign sel_hit = req_is_store ? st_hit : ld_hit;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:     if (accept && !sel_hit) state_d = ST_MISS_WAIT; // take_miss
            ST_MISS_WAIT: if (fill_valid)         state_d = ST_READY;     // fill_return
            default:                              state_d = ST_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Registered lookup result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_ppn   <= '0;
            rsp_size  <= PG_4K;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && sel_hit;
            rsp_miss  <= accept && !sel_hit;
            rsp_ppn   <= (accept && sel_hit) ? (req_is_store ? st_ppn : ld_ppn) : '0;
            rsp_size  <= (accept && sel_hit && req_is_store) ? st_size : PG_4K;
        end
    end

endmodule

// File: rtl/split_dtlb_chk.sv
module split_dtlb_chk
    import split_dtlb_pkg::*;
#(
    parameter int VPN_W = 36,
    parameter int PPN_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VPN_W-1:0] req_vpn,
    input logic             req_is_store,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [PPN_W-1:0] rsp_ppn,
    input logic [1:0]       rsp_size,
    input logic             fill_valid
);

    logic             st_q, flush_q;
    logic [VPN_W-1:0] vpn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= 1'b0;
            flush_q <= 1'b0;
            vpn_q   <= '0;
        end else begin
            flush_q <= flush;
            if (req_valid && req_ready) begin
                st_q  <= req_is_store;
                vpn_q <= req_vpn;
            end
        end
    end

    logic [PPN_W-1:0] pmsk;
    assign pmsk = PPN_W'(page_mask(pg_size_e'(rsp_size)));

    assert_rsp_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    assert_hit_miss_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_miss));

    assert_miss_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> !req_ready);

    assert_hold_until_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !fill_valid) |=> !req_ready);

    assert_load_size_4k_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !st_q) |-> (rsp_size == 2'd0));

    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && st_q) |-> ((rsp_ppn & pmsk) == (PPN_W'(vpn_q) & pmsk)));

    assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && req_valid && req_ready) |=> !rsp_hit);

endmodule

bind split_dtlb split_dtlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vpn     (req_vpn),
    .req_is_store(req_is_store),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_ppn     (rsp_ppn),
    .rsp_size    (rsp_size),
    .fill_valid  (fill_valid)
);

// File: tb/split_dtlb_bench.sv
module split_dtlb_bench;

    localparam int VW = 36;
    localparam int PW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [VW-1:0] req_vpn = '0;
    logic          req_is_store = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_miss;
    logic [PW-1:0] rsp_ppn;
    logic [1:0]    rsp_size;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_ppn = '0;
    logic [1:0]    fill_size = 2'd0;
    logic          fill_is_store = 1'b0;

    always #5 clk = ~clk;

    split_dtlb u_split_dtlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .req_is_store(req_is_store),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_ppn(rsp_ppn), .rsp_size(rsp_size),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_size(fill_size), .fill_is_store(fill_is_store)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input int rid, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rid, what, act, exp);
        end
    endtask

    // Issue one lookup; returns at the falling edge where the result is visible
    task automatic lookup(input logic [VW-1:0] vpn, input logic st);
        while (!req_ready) @(negedge clk);
        req_valid    = 1'b1;
        req_vpn      = vpn;
        req_is_store = st;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] ppn,
                        input logic [1:0] sz, input logic st);
        fill_valid    = 1'b1;
        fill_vpn      = vpn;
        fill_ppn      = ppn;
        fill_size     = sz;
        fill_is_store = st;
        @(posedge clk);
        #1 fill_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_hit(input logic [VW-1:0] vpn, input logic st,
                              input logic [PW-1:0] eppn, input logic [1:0] esz, input int rid);
        lookup(vpn, st);
        check(rsp_valid && rsp_hit && !rsp_miss, rid, "hit", {rsp_hit, rsp_miss}, 2'b10);
        check(rsp_ppn == eppn && rsp_size == esz, rid, "ppn/size",
              {rsp_ppn, rsp_size}, {eppn, esz});
    endtask

    task automatic expect_miss(input logic [VW-1:0] vpn, input logic st, input int rid);
        lookup(vpn, st);
        check(rsp_valid && !rsp_hit && rsp_miss, rid, "miss", {rsp_hit, rsp_miss}, 2'b01);
    endtask

    // op: 0 load lookup, 1 store lookup, 2 load fill, 3 store fill
    typedef struct packed {
        logic [1:0]    op;
        logic [VW-1:0] vpn;
        logic [PW-1:0] ppn;
        logic [1:0]    sz;
        logic          ehit;
        logic [3:0]    rid;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 36'h123,    28'h0,     2'd0, 1'b0, 4'd6},   // R6 cold load miss
        '{2'd2, 36'h123,    28'hABC,   2'd0, 1'b0, 4'd3},
        '{2'd0, 36'h123,    28'hABC,   2'd0, 1'b1, 4'd6},   // R6 load hit, size 0
        '{2'd1, 36'h123,    28'h0,     2'd0, 1'b0, 4'd1},   // R1 / R4 store misses
        '{2'd3, 36'h123,    28'hABC,   2'd0, 1'b0, 4'd4},
        '{2'd1, 36'h123,    28'hABC,   2'd0, 1'b1, 4'd5},   // R5 4 KB store hit
        '{2'd1, 36'h40077,  28'h0,     2'd0, 1'b0, 4'd5},
        '{2'd3, 36'h40005,  28'h200,   2'd1, 1'b0, 4'd5},
        '{2'd1, 36'h40077,  28'h277,   2'd1, 1'b1, 4'd5},   // R5 2 MB offset pass
        '{2'd0, 36'h40005,  28'h205,   2'd0, 1'b1, 4'd3},   // R3 store fill in load side
        '{2'd0, 36'h40077,  28'h0,     2'd0, 1'b0, 4'd2},   // R2 load ignores store side
        '{2'd2, 36'h40077,  28'h300,   2'd0, 1'b0, 4'd3},
        '{2'd3, 36'hC0000,  28'h40000, 2'd3, 1'b0, 4'd5},
        '{2'd1, 36'hC1234,  28'h41234, 2'd3, 1'b1, 4'd5},   // R5 1 GB
        '{2'd3, 36'h200400, 28'h800,   2'd2, 1'b0, 4'd5},
        '{2'd1, 36'h2007FF, 28'hBFF,   2'd2, 1'b1, 4'd5},   // R5 4 MB
        '{2'd3, 36'h123,    28'hDEF,   2'd0, 1'b0, 4'd11},
        '{2'd1, 36'h123,    28'hDEF,   2'd0, 1'b1, 4'd11},  // R11 store side replaced
        '{2'd0, 36'h123,    28'hDEF,   2'd0, 1'b1, 4'd11},  // R11 load side replaced
        '{2'd0, 36'h40077,  28'h300,   2'd0, 1'b1, 4'd6}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R9, R10)
        check(req_ready == 1'b1, 10, "ready in reset", req_ready, 1);
        check(rsp_valid == 1'b0, 9, "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                2'd0, 2'd1:
                    if (VEC[i].ehit) expect_hit(VEC[i].vpn, VEC[i].op[0], VEC[i].ppn, VEC[i].sz, int'(VEC[i].rid));
                    else             expect_miss(VEC[i].vpn, VEC[i].op[0], int'(VEC[i].rid));
                default:
                    fill(VEC[i].vpn, VEC[i].ppn, VEC[i].sz, VEC[i].op[0]);
            endcase
        end

        // R9: result lasts exactly one cycle
        expect_hit(36'h123, 1'b0, 28'hDEF, 2'd0, 9);
        @(negedge clk);
        check(rsp_valid == 1'b0, 9, "rsp_valid one cycle", rsp_valid, 0);

        // R10: ready held low through a wait with no fill
        expect_miss(36'h9999, 1'b0, 10);
        check(req_ready == 1'b0, 10, "ready after miss", req_ready, 0);
        repeat (3) @(negedge clk);
        check(req_ready == 1'b0, 10, "ready while waiting", req_ready, 0);
        fill(36'h9999, 28'h99, 2'd0, 1'b0);
        check(req_ready == 1'b1, 10, "ready after fill", req_ready, 1);

        // R12: flush empties both arrays
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
        @(negedge clk);
        expect_miss(36'h123, 1'b0, 12);
        fill(36'h5555, 28'h1, 2'd0, 1'b0);
        expect_miss(36'h2007FF, 1'b1, 12);
        fill(36'h5556, 28'h1, 2'd0, 1'b0);

        // R8: round-robin store replacement after invalid entries are used
        for (int k = 0; k < 17; k++) fill(36'h1000 + 36'(k), 28'h500 + 28'(k), 2'd0, 1'b1);
        expect_miss(36'h1000, 1'b1, 8);
        fill(36'h7777, 28'h7, 2'd0, 1'b0);
        expect_hit(36'h1001, 1'b1, 28'h501, 2'd0, 8);
        expect_hit(36'h1010, 1'b1, 28'h510, 2'd0, 8);

        // R7: pseudo-LRU victim in one four-way set (set 0)
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
        @(negedge clk);
        fill(36'h10, 28'h10, 2'd0, 1'b0);
        fill(36'h20, 28'h20, 2'd0, 1'b0);
        fill(36'h30, 28'h30, 2'd0, 1'b0);
        fill(36'h40, 28'h40, 2'd0, 1'b0);
        expect_hit(36'h20, 1'b0, 28'h20, 2'd0, 7);
        fill(36'h50, 28'h50, 2'd0, 1'b0);
        expect_hit(36'h10, 1'b0, 28'h10, 2'd0, 7);
        expect_hit(36'h20, 1'b0, 28'h20, 2'd0, 7);
        expect_hit(36'h40, 1'b0, 28'h40, 2'd0, 7);
        expect_hit(36'h50, 1'b0, 28'h50, 2'd0, 7);
        expect_miss(36'h30, 1'b0, 7);
        fill(36'h61, 28'h61, 2'd0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule